// File: doc/BRIEF.md
# Quadrature Decoder with Index Control

This block sits between an incremental encoder and an up/down counter. It synchronizes the encoder's two phase lines and its once-per-revolution index line to the system clock. It then converts their transitions into a one-cycle count-enable pulse and a direction level for the counter. It also watches the index line and issues a one-cycle request to load the counter's preset value, and it drives a general-purpose flag pin. That pin can show one of the counter's status conditions or the index itself.

A host configures the block through an 8-bit command write port. The top three bits of each byte pick a target: a flag command, the mode register, the I/O control register or the index control register. The lower bits carry that target's fields. The counter is outside this block; its carry, borrow and compare status only come back in to feed the flag pin.

Top module: `quad_index_decoder`

## Requirements
- R1: While rstN is low and after its release, countEn=0, countUp=1, noiseErr=0, presetLoad=0 and flagOut=1 (with cntCarry low). The configuration is non-quadrature mode, phase inputs disabled, preset-on-index selected, carry on the flag pin, and the index function off with negative polarity.
- R2: Non-quadrature mode (mode field 0): every rising edge of A gives one count, and B's level gives the direction (1 = up). countEn rises three clock edges after the A change reaches the pin. countUp changes only on a cycle where countEn is 1.
- R3: Mode 1 (x1): one count per full phase cycle, on the A rising edge. It counts up when B is 0 at that edge and down when B is 1.
- R4: Mode 2 (x2): one count on every edge of A. The direction is up when A and B differ after the edge, and down otherwise.
- R5: Mode 3 (x4): one count on every single edge of A or B. After an A edge the direction is up when A differs from B. After a B edge it is up when A equals B.
- R6: While the phase-enable bit is 0, no count pulse is produced, whatever A and B do.
- R7: In any quadrature mode with the phase inputs enabled, a step in which A and B both change between successive samples sets the sticky noiseErr flag and produces no count. The flag command 0x06 (opcode 000, bits 2:1 = 11) clears it; a new noise event in the same cycle wins over the clear. In non-quadrature mode such a step never sets the flag.
- R8: The index function cannot be on in non-quadrature mode. Writing mode 0 turns it off. An index control write that asks for it while in mode 0 leaves it off.
- R9: When the index function is on and preset-on-index is selected, an index change from inactive to active gives a single presetLoad pulse. The active level is high when the polarity bit is 1 and low when it is 0. Setting the preset-disable bit suppresses the pulse. idxLevel shows the synchronized index pin.
- R10: The flag select field sets flagOut. Value 0 gives NOT carry, 1 gives NOT compare, 2 gives NOT (carry OR borrow), and 3 gives index active (high when the index is at its active level).
- R11: Command byte layout, with the opcode in bits 7:5:
  - 001: mode, with the field in bits 4:3.
  - 010: I/O control, with bit 0 the phase enable, bit 1 the preset disable and bits 4:3 the flag select.
  - 011: index control, with bit 0 the function enable and bit 1 the polarity.
  - 000: flag command.
  - Opcodes 100 to 111 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| encA | input | 1 | Encoder phase A (asynchronous) |
| encB | input | 1 | Encoder phase B (asynchronous) |
| encIdx | input | 1 | Encoder index (asynchronous) |
| cntCarry | input | 1 | Counter carry status |
| cntBorrow | input | 1 | Counter borrow status |
| cntCompare | input | 1 | Counter compare status |
| wrEn | input | 1 | Command byte valid |
| wrData | input | 8 | Command byte |
| countEn | output | 1 | One-cycle count pulse |
| countUp | output | 1 | Count direction, 1 = up |
| noiseErr | output | 1 | Sticky illegal-transition flag |
| idxLevel | output | 1 | Synchronized index level |
| presetLoad | output | 1 | One-cycle preset load request |
| flagOut | output | 1 | Selectable flag pin |

## Verification
The hardest situations to reach are the interactions between configuration and index history. These are an index function requested or left on across a switch to non-quadrature mode, and a polarity change made while the index line sits still. The bench gets there with command sequences that enable the function in x4 mode, flip its polarity with the index idle, and then drop to mode 0 and request it again. After each step it pulses the index line and counts presetLoad pulses. Illegal double-phase steps are forced by moving A and B in the same cycle. Each step is driven slowly enough that the three-stage path to the outputs settles before the next one.

// File: rtl/qdec_pkg.sv
package qdec_pkg;
  localparam logic [2:0] OP_FLAG = 3'd0;
  localparam logic [2:0] OP_MODE = 3'd1;
  localparam logic [2:0] OP_IOC  = 3'd2;
  localparam logic [2:0] OP_IDX  = 3'd3;

  typedef struct packed {
    logic [1:0] quadMode;
    logic       abEn;
    logic       presetDis;
    logic [1:0] flgSel;
    logic       idxFnEn;
    logic       idxPol;
  } qdecCfg_t;

  typedef struct packed {
    logic errClr;
  } qdecStrobe_t;
endpackage

// File: rtl/qdec_ctrl.sv
module qdec_ctrl
  import qdec_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] wrData,
  output qdecCfg_t         cfg,
  output qdecStrobe_t      strb
);
  localparam int OP_LSB = CMD_W - 3;

  logic [2:0] opCode;
  assign opCode = wrData[OP_LSB +: 3];

  always_comb begin
    strb = '0;
    strb.errClr = wrEn && (opCode == OP_FLAG) && (wrData[2:1] == 2'b11);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfg <= '0;
    end else if (wrEn) begin
      case (opCode)
        OP_MODE: begin
          cfg.quadMode <= wrData[4:3];
          if (wrData[4:3] == 2'd0) cfg.idxFnEn <= 1'b0;
        end
        OP_IOC: begin
          cfg.abEn      <= wrData[0];
          cfg.presetDis <= wrData[1];
          cfg.flgSel    <= wrData[4:3];
        end
        OP_IDX: begin
          cfg.idxPol  <= wrData[1];
          cfg.idxFnEn <= wrData[0] && (cfg.quadMode != 2'd0);
        end
        default: ;
      endcase
    end
  end

  // R8
  idx_fn_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.quadMode == 2'd0) |-> !cfg.idxFnEn);
endmodule

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        encA,
  input  logic        encB,
  input  logic        encIdx,
  input  logic        cntCarry,
  input  logic        cntBorrow,
  input  logic        cntCompare,
  input  qdecCfg_t    cfg,
  input  qdecStrobe_t strb,
  output logic        countEn,
  output logic        countUp,
  output logic        noiseErr,
  output logic        idxLevel,
  output logic        presetLoad,
  output logic        flagOut
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [2:0] syncStage [SYNC_STAGES];
  logic curA, curB, curIdx, prevA, prevB, prevIdx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < SYNC_STAGES; g++) syncStage[g] <= '0;
      prevA <= 1'b0;
      prevB <= 1'b0;
      prevIdx <= 1'b0;
    end else begin
      syncStage[0] <= {encIdx, encB, encA};
      for (int g = 1; g < SYNC_STAGES; g++) syncStage[g] <= syncStage[g-1];
      prevA <= curA;
      prevB <= curB;
      prevIdx <= curIdx;
    end
  end

  assign curA   = syncStage[LAST][0];
  assign curB   = syncStage[LAST][1];
  assign curIdx = syncStage[LAST][2];

  logic aChg, bChg, isQuad, stepHit, cntHit, dirUp, badStep;
  logic idxAct, idxActPrev, loadHit;

  always_comb begin
    aChg   = curA ^ prevA;
    bChg   = curB ^ prevB;
    isQuad = cfg.quadMode != 2'd0;
    case (cfg.quadMode)
      2'd0:    stepHit = aChg & curA;
      2'd1:    stepHit = aChg & curA & ~bChg;
      2'd2:    stepHit = aChg & ~bChg;
      default: stepHit = aChg ^ bChg;
    endcase
    cntHit     = cfg.abEn & stepHit;
    dirUp      = !isQuad ? curB : (aChg ? (curA ^ curB) : ~(curA ^ curB));
    badStep    = isQuad & cfg.abEn & aChg & bChg;
    idxAct     = ~(curIdx ^ cfg.idxPol);
    idxActPrev = ~(prevIdx ^ cfg.idxPol);
    loadHit    = cfg.idxFnEn & ~cfg.presetDis & idxAct & ~idxActPrev;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countEn    <= 1'b0;
      countUp    <= 1'b1;
      noiseErr   <= 1'b0;
      presetLoad <= 1'b0;
    end else begin
      countEn    <= cntHit;
      if (cntHit) countUp <= dirUp;
      noiseErr   <= badStep | (noiseErr & ~strb.errClr);
      presetLoad <= loadHit;
    end
  end

  assign idxLevel = curIdx;

  always_comb begin
    case (cfg.flgSel)
      2'd0:    flagOut = ~cntCarry;
      2'd1:    flagOut = ~cntCompare;
      2'd2:    flagOut = ~(cntCarry | cntBorrow);
      default: flagOut = idxAct;
    endcase
  end

  // R6
  gate_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.abEn |=> !countEn);
  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (noiseErr && !strb.errClr) |=> noiseErr);
  // R9
  load_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    presetLoad |-> $past(cfg.idxFnEn && !cfg.presetDis));
  // R2
  dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(countUp) |-> countEn);
endmodule

// File: rtl/quad_index_decoder.sv
module quad_index_decoder
  import qdec_pkg::*;
#(
  parameter int CMD_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             encA,
  input  logic             encB,
  input  logic             encIdx,
  input  logic             cntCarry,
  input  logic             cntBorrow,
  input  logic             cntCompare,
  input  logic             wrEn,
  input  logic [CMD_W-1:0] wrData,
  output logic             countEn,
  output logic             countUp,
  output logic             noiseErr,
  output logic             idxLevel,
  output logic             presetLoad,
  output logic             flagOut
);
  qdecCfg_t    cfg;
  qdecStrobe_t strb;

  qdec_ctrl #(.CMD_W(CMD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .cfg(cfg), .strb(strb)
  );

  qdec_datapath #(.SYNC_STAGES(SYNC_STAGES)) uData (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encIdx(encIdx),
    .cntCarry(cntCarry), .cntBorrow(cntBorrow), .cntCompare(cntCompare),
    .cfg(cfg), .strb(strb),
    .countEn(countEn), .countUp(countUp), .noiseErr(noiseErr),
    .idxLevel(idxLevel), .presetLoad(presetLoad), .flagOut(flagOut)
  );
endmodule

// File: tb/quad_index_decoder_test.sv
`timescale 1ns/1ps
module quad_index_decoder_test;
  logic clk = 1'b0, rstN = 1'b0;
  logic encA = 0, encB = 0, encIdx = 0;
  logic cntCarry = 0, cntBorrow = 0, cntCompare = 0;
  logic wrEn = 0;
  logic [7:0] wrData = 8'h00;
  logic countEn, countUp, noiseErr, idxLevel, presetLoad, flagOut;

  int total = 0, bad = 0, cntSeen = 0, loadSeen = 0;
  string phaseTag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  quad_index_decoder uut (
    .clk(clk), .rstN(rstN), .encA(encA), .encB(encB), .encIdx(encIdx),
    .cntCarry(cntCarry), .cntBorrow(cntBorrow), .cntCompare(cntCompare),
    .wrEn(wrEn), .wrData(wrData),
    .countEn(countEn), .countUp(countUp), .noiseErr(noiseErr),
    .idxLevel(idxLevel), .presetLoad(presetLoad), .flagOut(flagOut)
  );

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s (%s) %s: actual=%0d expected=%0d at %0t",
               tag, phaseTag, what, act, exp, $time);
    end
  endtask

  // behavioural reference: sample history and configuration mirror
  bit hA[4], hB[4], hI[4];
  bit [1:0] mMode, mFlg;
  bit mAb, mPd, mFn, mPol;
  bit eCnt, eUp, eErr, eLoad;

  always @(posedge clk) begin
    bit a, pa, b, pb, ic, ip, aC, bC, hit, up, badStep, clr, eFlag;
    string cTag;
    if (!rstN) begin
      for (int i = 0; i < 4; i++) begin hA[i] = 0; hB[i] = 0; hI[i] = 0; end
      mMode = 0; mFlg = 0; mAb = 0; mPd = 0; mFn = 0; mPol = 0;
      eCnt = 0; eUp = 1; eErr = 0; eLoad = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin hA[i] = hA[i-1]; hB[i] = hB[i-1]; hI[i] = hI[i-1]; end
      hA[0] = encA; hB[0] = encB; hI[0] = encIdx;
      a = hA[2]; pa = hA[3]; b = hB[2]; pb = hB[3]; ic = hI[2]; ip = hI[3];
      aC = a ^ pa; bC = b ^ pb;
      case (mMode)
        2'd0: hit = aC & a;
        2'd1: hit = aC & a & !bC;
        2'd2: hit = aC & !bC;
        default: hit = aC ^ bC;
      endcase
      hit = hit & mAb;
      up = (mMode == 0) ? b : (aC ? (a ^ b) : !(a ^ b));
      eCnt = hit;
      if (hit) eUp = up;
      badStep = (mMode != 0) && mAb && aC && bC;
      clr = wrEn && wrData[7:5] == 3'd0 && wrData[2:1] == 2'b11;
      eErr = badStep | (eErr & !clr);
      eLoad = mFn && !mPd && (ic == mPol) && (ip != mPol);
      if (wrEn) begin
        case (wrData[7:5])
          3'd1: begin mMode = wrData[4:3]; if (wrData[4:3] == 2'd0) mFn = 0; end
          3'd2: begin mAb = wrData[0]; mPd = wrData[1]; mFlg = wrData[4:3]; end
          3'd3: begin mPol = wrData[1]; mFn = wrData[0] && (mMode != 0); end
          default: ;
        endcase
      end
    end
    #1;
    if (!done) begin
      cTag = !rstN ? "R1" : !mAb ? "R6" : mMode == 0 ? "R2" : mMode == 1 ? "R3" :
             mMode == 2 ? "R4" : "R5";
      case (mFlg)
        2'd0: eFlag = !cntCarry;
        2'd1: eFlag = !cntCompare;
        2'd2: eFlag = !(cntCarry | cntBorrow);
        default: eFlag = (hI[1] == mPol);
      endcase
      chk(cTag, "countEn", countEn, eCnt);
      chk(cTag, "countUp", countUp, eUp);
      chk(!rstN ? "R1" : "R7", "noiseErr", noiseErr, eErr);
      chk(!rstN ? "R1" : "R9", "presetLoad", presetLoad, eLoad);
      chk("R9", "idxLevel", idxLevel, hI[1]);
      chk(!rstN ? "R1" : "R10", "flagOut", flagOut, eFlag);
      if (countEn) cntSeen++;
      if (presetLoad) loadSeen++;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] c);
    @(negedge clk); wrEn = 1; wrData = c;
    @(negedge clk); wrEn = 0; wrData = 8'h00;
  endtask

  task automatic setAB(bit a, bit b);
    @(negedge clk); encA = a; encB = b;
    tick(3);
  endtask

  task automatic fwd(int n);
    for (int i = 0; i < n; i++) begin setAB(1,0); setAB(1,1); setAB(0,1); setAB(0,0); end
  endtask

  task automatic rev(int n);
    for (int i = 0; i < n; i++) begin setAB(0,1); setAB(1,1); setAB(1,0); setAB(0,0); end
  endtask

  task automatic idxPulse();
    @(negedge clk); encIdx = ~encIdx; tick(5);
    @(negedge clk); encIdx = ~encIdx; tick(5);
  endtask

  task automatic finishRun();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    tick(4);
    @(negedge clk); rstN = 1;
    tick(2);

    phaseTag = "R6"; cntSeen = 0;
    setAB(1,1); setAB(0,1); setAB(1,0); setAB(0,0); tick(4);
    chk("R6", "counts with inputs gated", cntSeen, 0);

    phaseTag = "R2";
    wr(8'h41); tick(4); cntSeen = 0;
    setAB(0,1); setAB(1,1); setAB(0,1); setAB(1,0); setAB(0,0); setAB(1,0); setAB(0,0);
    tick(4);
    chk("R2", "non-quadrature counts", cntSeen, 3);
    chk("R7", "no error in non-quadrature", noiseErr, 0);

    phaseTag = "R3";
    wr(8'h28); tick(4); cntSeen = 0;
    fwd(3); rev(2); tick(4);
    chk("R3", "x1 counts", cntSeen, 5);

    phaseTag = "R4";
    wr(8'h30); tick(4); cntSeen = 0;
    fwd(2); rev(1); tick(4);
    chk("R4", "x2 counts", cntSeen, 6);

    phaseTag = "R5";
    wr(8'h38); tick(4); cntSeen = 0;
    fwd(2); rev(2); tick(4);
    chk("R5", "x4 counts", cntSeen, 16);

    phaseTag = "R7";
    setAB(1,1); tick(3);
    chk("R7", "error after double step", noiseErr, 1);
    setAB(0,0); tick(3);
    wr(8'h06); tick(2);
    chk("R7", "error cleared", noiseErr, 0);

    phaseTag = "R9";
    wr(8'h63); tick(3); loadSeen = 0;
    idxPulse();
    chk("R9", "loads positive polarity", loadSeen, 1);
    wr(8'h61); tick(3); loadSeen = 0;
    idxPulse();
    chk("R9", "loads negative polarity", loadSeen, 1);
    wr(8'h43); wr(8'h63); tick(3); loadSeen = 0;
    idxPulse();
    chk("R9", "loads with preset disabled", loadSeen, 0);

    phaseTag = "R8";
    wr(8'h41); wr(8'h63); tick(3);
    wr(8'h20); tick(3); loadSeen = 0;
    idxPulse();
    chk("R8", "loads after mode 0 forced off", loadSeen, 0);
    wr(8'h63); tick(3); loadSeen = 0;
    idxPulse();
    chk("R8", "loads after request in mode 0", loadSeen, 0);

    phaseTag = "R10";
    for (int s = 0; s < 4; s++) begin
      wr(8'h41 | 8'(s << 3));
      for (int k = 0; k < 8; k++) begin
        @(negedge clk); {cntCarry, cntBorrow, cntCompare} = 3'(k);
        tick(2);
      end
      @(negedge clk); encIdx = ~encIdx; tick(4);
    end
    wr(8'h59); @(negedge clk); encIdx = 1; tick(3);
    chk("R10", "flag shows index", flagOut, 1);
    cntCarry = 0; cntBorrow = 0; cntCompare = 0;
    encIdx = 0;

    phaseTag = "R11";
    wr(8'h39); wr(8'h41); tick(4);
    wr(8'hE0); wr(8'hA2); wr(8'h9F); wr(8'hC7); tick(3); cntSeen = 0;
    fwd(1); tick(4);
    chk("R11", "ignored opcodes keep x4", cntSeen, 4);
    chk("R11", "ignored opcodes keep carry flag", flagOut, 1);

    phaseTag = "R1";
    @(negedge clk); rstN = 0; tick(2);
    chk("R1", "countUp in reset", countUp, 1);
    chk("R1", "flagOut in reset", flagOut, 1);
    @(negedge clk); rstN = 1; tick(3);
    finishRun();
  end
endmodule